// File: doc/BRIEF.md
# IDE Controller Indexed Configuration Registers

This block is the configuration store of an IDE interface controller. The host reaches it through two byte-wide I/O locations. The select location is at offset 0 and the window location is at offset 4. A write to offset 0 chooses a register. A read or write at offset 4 then acts on the chosen register. The store holds a configuration byte, a control byte, a command-block timing byte, per-drive address-setup and read/write timing bytes, a prefetch burst byte and a scratch byte. The scratch byte lets probing software confirm that the device is present.

Some bit positions are driven by the device itself and cannot be written. These are the silicon revision, a device identity field, a strap that reports the alternate port base, and the interrupt status of the two channels. The stored fields leave the block on dedicated outputs that feed the drive-timing engine.

Top module: `ide_cfg_regfile`

## Requirements
- R1: A write at offset 0 loads the 8-bit register selector on that clock edge. A read at offset 0 returns the current selector.
- R2: A read at offset 4 returns the full stored byte of the selected register, and a write at offset 4 replaces it. This applies to selectors 0x51 (control), 0x52 (command-block timing), 0x53 and 0x55 (address setup of drives 0 and 1), 0x54 and 0x56 (read/write timing of drives 0 and 1), 0x58 (shared read/write timing of the secondary drives) and 0x59 (burst size).
- R3: At selector 0x50, bits 1:0 read the revision parameter (default 2, must be nonzero), bits 4:3 read the device identity parameter (default 1) and bit 5 reads the alternate-base strap parameter (default 1). None of these bits can be written. Bits 7:6 are writable storage.
- R4: Bit 2 at selector 0x50 reports the primary interrupt input. Bit 4 at selector 0x57 reports the secondary interrupt input. Each bit shows the level its input had at the previous clock edge, so it sets while the input is high and clears once the input falls. Host writes to these two bit positions have no effect.
- R5: Selector 0x5B is a plain read/write byte. A written 0xBD reads back as 0xBD.
- R6: Any selector not listed in R2 to R5 reads 0x00, and writes to it change no readable value or output.
- R7: After reset: control 0x51 holds 0xC0 (read-ahead off for drives 0 and 1, secondary channel off), 0x57 holds 0x0C (read-ahead off for drives 2 and 3), burst 0x59 holds 0x40 (512 bytes), and every other stored byte and the selector are 0x00 (slowest timings).
- R8: The outputs follow the stored fields from the clock edge of the write onward: `sec_en` is 0x51 bit 3; `ra_off` is {0x57 bit 3, 0x57 bit 2, 0x51 bit 7, 0x51 bit 6}; the timing and burst outputs carry the bytes of their registers, with bit 4 of `addr_tim23` reading 0.
- R9: Accesses at offsets other than 0 and 4 are ignored. Writes there change nothing, and reads there return 0x00.
- R10: `rdata` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| io_off | input | 3 | Offset from the port base (0 = selector, 4 = window) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational |
| irq_pri | input | 1 | Primary channel interrupt level |
| irq_sec | input | 1 | Secondary channel interrupt level |
| sec_en | output | 1 | Secondary channel enable |
| ra_off | output | 4 | Per-drive read-ahead disable, drive 0 in bit 0 |
| cmd_tim | output | 8 | Command-block timing byte |
| addr_tim0 | output | 8 | Drive 0 address-setup byte |
| rw_tim0 | output | 8 | Drive 0 read/write timing byte |
| addr_tim1 | output | 8 | Drive 1 address-setup byte |
| rw_tim1 | output | 8 | Drive 1 read/write timing byte |
| addr_tim23 | output | 8 | Secondary drives address-setup and read-ahead byte |
| rw_tim23 | output | 8 | Secondary drives read/write timing byte |
| burst_sel | output | 8 | Prefetch burst size byte |

## Verification
The bench aims at the registers that mix stored and device-driven bits. It writes 0xFF and 0x00 to 0x50 and 0x57 while the interrupt inputs toggle. A design that let the host overwrite the revision or the status bits, or that latched status instead of following the input, would read back the written value or a stale level.

Selectors just outside the implemented range are also targeted: 0x4F, 0x5A, 0x5C and 0xFF. So are the offsets 1 to 3 and 5 to 7. An off-by-one decode or a partial offset compare would alias these onto a real register and show a nonzero read or a moved output.

Reset values are read back before any write, so a wrong read-ahead or burst default shows at once. A long pseudo-random sequence follows, so that selector writes and window accesses interleave in every order.

// File: rtl/ide_cfg_regfile.sv
module ide_cfg_regfile #(
  parameter logic [1:0] REV      = 2'd2,
  parameter logic [1:0] DEV_ID   = 2'd1,
  parameter logic       ALT_BASE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] io_off,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       irq_pri,
  input  logic       irq_sec,
  output logic       sec_en,
  output logic [3:0] ra_off,
  output logic [7:0] cmd_tim,
  output logic [7:0] addr_tim0,
  output logic [7:0] rw_tim0,
  output logic [7:0] addr_tim1,
  output logic [7:0] rw_tim1,
  output logic [7:0] addr_tim23,
  output logic [7:0] rw_tim23,
  output logic [7:0] burst_sel
);

  localparam logic [2:0] SEL_OFF = 3'd0;
  localparam logic [2:0] WIN_OFF = 3'd4;

  logic [7:0] idx_q;
  logic [1:0] cfg_hi_q;
  logic [7:0] ctrl_q, cmdt_q, at0_q, rw0_q, at1_q, rw1_q, at23_q, rw23_q, burst_q, scratch_q;
  logic       irqp_q, irqs_q;

  wire sel_wr = wr_en && (io_off == SEL_OFF);
  wire win_wr = wr_en && (io_off == WIN_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= 8'h00;
      cfg_hi_q  <= 2'b00;
      ctrl_q    <= 8'hC0;
      cmdt_q    <= 8'h00;
      at0_q     <= 8'h00;
      rw0_q     <= 8'h00;
      at1_q     <= 8'h00;
      rw1_q     <= 8'h00;
      at23_q    <= 8'h0C;
      rw23_q    <= 8'h00;
      burst_q   <= 8'h40;
      scratch_q <= 8'h00;
      irqp_q    <= 1'b0;
      irqs_q    <= 1'b0;
    end else begin
      irqp_q <= irq_pri;
      irqs_q <= irq_sec;
      if (sel_wr) idx_q <= wdata;
      if (win_wr) begin
        case (idx_q)
          8'h50: cfg_hi_q  <= wdata[7:6];
          8'h51: ctrl_q    <= wdata;
          8'h52: cmdt_q    <= wdata;
          8'h53: at0_q     <= wdata;
          8'h54: rw0_q     <= wdata;
          8'h55: at1_q     <= wdata;
          8'h56: rw1_q     <= wdata;
          8'h57: at23_q    <= {wdata[7:5], 1'b0, wdata[3:0]};
          8'h58: rw23_q    <= wdata;
          8'h59: burst_q   <= wdata;
          8'h5B: scratch_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  logic [7:0] win_val;
  always_comb begin
    case (idx_q)
      8'h50:   win_val = {cfg_hi_q, ALT_BASE, DEV_ID, irqp_q, REV};
      8'h51:   win_val = ctrl_q;
      8'h52:   win_val = cmdt_q;
      8'h53:   win_val = at0_q;
      8'h54:   win_val = rw0_q;
      8'h55:   win_val = at1_q;
      8'h56:   win_val = rw1_q;
      8'h57:   win_val = {at23_q[7:5], irqs_q, at23_q[3:0]};
      8'h58:   win_val = rw23_q;
      8'h59:   win_val = burst_q;
      8'h5B:   win_val = scratch_q;
      default: win_val = 8'h00;
    endcase
  end

  assign rdata = !rd_en              ? 8'h00 :
                 (io_off == SEL_OFF) ? idx_q :
                 (io_off == WIN_OFF) ? win_val : 8'h00;

  assign sec_en     = ctrl_q[3];
  assign ra_off     = {at23_q[3], at23_q[2], ctrl_q[7], ctrl_q[6]};
  assign cmd_tim    = cmdt_q;
  assign addr_tim0  = at0_q;
  assign rw_tim0    = rw0_q;
  assign addr_tim1  = at1_q;
  assign rw_tim1    = rw1_q;
  assign addr_tim23 = at23_q;
  assign rw_tim23   = rw23_q;
  assign burst_sel  = burst_q;

endmodule

// File: rtl/ide_cfg_regfile_chk.sv
module ide_cfg_regfile_chk #(
  parameter logic [1:0] REV = 2'd2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] io_off,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq_pri,
  input logic       irq_sec,
  input logic       sec_en,
  input logic [3:0] ra_off,
  input logic [7:0] idx_q
);

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  wire win_rd = rd_en && (io_off == 3'd4);
  wire win_wr = wr_en && (io_off == 3'd4);

  assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && io_off == 3'd0) |=> (idx_q == $past(wdata)));

  assert_rev_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && idx_q == 8'h50) |-> (rdata[1:0] == REV));

  assert_pri_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && win_rd && idx_q == 8'h50) |-> (rdata[2] == $past(irq_pri)));

  assert_sec_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && win_rd && idx_q == 8'h57) |-> (rdata[4] == $past(irq_sec)));

  assert_gap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && idx_q == 8'h5A) |-> (rdata == 8'h00));

  assert_sec_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && idx_q == 8'h51) |=> (sec_en == $past(wdata[3])));

  assert_ra_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> $stable(ra_off));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00));

endmodule

bind ide_cfg_regfile ide_cfg_regfile_chk #(.REV(REV)) u_chk (.*);

// File: tb/tb_ide_cfg_regfile.sv
module tb_ide_cfg_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] io_off = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic irq_pri = 1'b0, irq_sec = 1'b0;
  logic [7:0] rdata;
  logic sec_en;
  logic [3:0] ra_off;
  logic [7:0] cmd_tim, addr_tim0, rw_tim0, addr_tim1, rw_tim1, addr_tim23, rw_tim23, burst_sel;

  always #2.5 clk = ~clk;

  ide_cfg_regfile dut (.*);

  int vectors = 0, fails = 0, cycles = 0;
  bit reset_phase = 1'b1;

  logic [7:0] m_idx;
  logic [7:0] m_reg [0:255];
  logic m_p, m_s;

  function automatic bit implemented(input logic [7:0] s);
    return (s >= 8'h50 && s <= 8'h59) || s == 8'h5B;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 8'h00;
      for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
      m_reg[8'h51] = 8'hC0;
      m_reg[8'h57] = 8'h0C;
      m_reg[8'h59] = 8'h40;
      m_p = 1'b0;
      m_s = 1'b0;
    end else begin
      m_p = irq_pri;
      m_s = irq_sec;
      if (wr_en && io_off == 3'd4 && implemented(m_idx)) begin
        if (m_idx == 8'h50)      m_reg[m_idx] = wdata & 8'hC0;
        else if (m_idx == 8'h57) m_reg[m_idx] = wdata & 8'hEF;
        else                     m_reg[m_idx] = wdata;
      end
      if (wr_en && io_off == 3'd0) m_idx = wdata;
    end
  end

  function automatic logic [7:0] exp_rd();
    if (!rd_en) return 8'h00;
    if (io_off == 3'd0) return m_idx;
    if (io_off != 3'd4) return 8'h00;
    if (m_idx == 8'h50) return {m_reg[8'h50][7:6], 1'b1, 2'b01, m_p, 2'b10};
    if (m_idx == 8'h57) return m_reg[8'h57] | {3'b000, m_s, 4'b0000};
    if (implemented(m_idx)) return m_reg[m_idx];
    return 8'h00;
  endfunction

  function automatic string tag();
    if (reset_phase) return "R7";
    if (!rd_en) return "R10";
    if (io_off == 3'd0) return "R1";
    if (io_off != 3'd4) return "R9";
    if (m_idx == 8'h50) return "R3/R4";
    if (m_idx == 8'h57) return "R4";
    if (m_idx == 8'h5B) return "R5";
    if (!implemented(m_idx)) return "R6";
    return "R2";
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = exp_rd();
    cmp(tag(), "rdata", {24'h0, rdata}, {24'h0, e});
    cmp("R8", "sec_en", {31'h0, sec_en}, {31'h0, m_reg[8'h51][3]});
    cmp("R8", "ra_off", {28'h0, ra_off},
        {28'h0, m_reg[8'h57][3], m_reg[8'h57][2], m_reg[8'h51][7], m_reg[8'h51][6]});
    cmp("R8", "timing", {cmd_tim, addr_tim0, rw_tim0, addr_tim1},
        {m_reg[8'h52], m_reg[8'h53], m_reg[8'h54], m_reg[8'h55]});
    cmp("R8", "timing2", {rw_tim1, addr_tim23, rw_tim23, burst_sel},
        {m_reg[8'h56], m_reg[8'h57], m_reg[8'h58], m_reg[8'h59]});
  endtask

  task automatic step(input bit w, input bit r, input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; io_off = o; wdata = d;
    #1;
    check_all();
  endtask

  task automatic put(input logic [7:0] s, input logic [7:0] v);
    step(1'b1, 1'b0, 3'd0, s);
    step(1'b1, 1'b0, 3'd4, v);
  endtask

  task automatic get(input logic [7:0] s);
    step(1'b1, 1'b0, 3'd0, s);
    step(1'b0, 1'b1, 3'd4, 8'h00);
    step(1'b0, 1'b1, 3'd0, 8'h00);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: read every reset value before any write
    for (int s = 8'h4F; s <= 8'h5C; s++) begin
      step(1'b1, 1'b0, 3'd0, s[7:0]);
      step(1'b0, 1'b1, 3'd4, 8'h00);
    end
    step(1'b0, 1'b1, 3'd0, 8'h00);
    reset_phase = 1'b0;
    // R5 scratch presence pattern
    put(8'h5B, 8'hBD); get(8'h5B);
    // R3/R4 read-only bits against 0xFF and 0x00
    irq_pri = 1'b1;
    put(8'h50, 8'hFF); get(8'h50);
    irq_pri = 1'b0;
    step(1'b0, 1'b1, 3'd4, 8'h00);
    put(8'h50, 8'h00); get(8'h50);
    irq_sec = 1'b1;
    put(8'h57, 8'hFF); get(8'h57);
    irq_sec = 1'b0;
    step(1'b0, 1'b1, 3'd4, 8'h00);
    put(8'h57, 8'h00); get(8'h57);
    // R2/R8 all writable bytes
    for (int s = 8'h51; s <= 8'h59; s++) begin
      put(s[7:0], 8'hA5 ^ s[7:0]); get(s[7:0]);
    end
    put(8'h51, 8'h08); put(8'h51, 8'h37);
    put(8'h59, 8'h40);
    // R6 gap and out-of-range selectors
    put(8'h5A, 8'hAA); get(8'h5A);
    put(8'h4F, 8'h55); get(8'h4F);
    put(8'h5C, 8'h11); get(8'hFF);
    // R9 other offsets
    step(1'b1, 1'b0, 3'd0, 8'h52);
    for (int o = 1; o < 8; o++) begin
      if (o == 4) continue;
      step(1'b1, 1'b0, o[2:0], 8'hEE);
      step(1'b0, 1'b1, o[2:0], 8'h00);
    end
    step(1'b0, 1'b1, 3'd4, 8'h00);
    step(1'b0, 1'b0, 3'd4, 8'h00);
    // pseudo-random interleaving
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      irq_pri = lfsr[9];
      irq_sec = lfsr[3];
      step(lfsr[0], lfsr[1], lfsr[2] ? 3'd4 : (lfsr[5] ? lfsr[8:6] : 3'd0),
           lfsr[11] ? {4'h5, lfsr[15:12]} : lfsr[14:7]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule